// File: doc/BRIEF.md
# Bank-Interleaved Vector Element Mover

This block moves a short vector of elements between the lanes of a vector datapath and a word-addressed memory split into several independent banks. A request names a base address and either a stride or one index per element. From these the block forms one word address per element. Each address is sent to the bank picked by its low-order bits, and the remaining bits give the word within that bank. Loads collect the read words into a result vector. Stores write one word per lane. There is no cache, and every bank access takes the same fixed time, so the completion time of a request depends only on how its addresses fall across the banks.

Elements that land in different banks are served in the same cycle. Elements that share a bank wait their turn, one per cycle per bank, in element order. A request runs through four named states. `S_IDLE` accepts a request (transition *accept*, taken when `req_valid` is high). `S_ISSUE` dispatches granted elements to the banks every cycle (transition *issue_last*, taken when no element is left pending after this cycle's grants). `S_DRAIN` waits one cycle for the last read data (transition *drain_done*, unconditional). `S_DONE` presents the result for one cycle (transition *release*, unconditional, back to `S_IDLE`).

Top module: `vec_bank_mover`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A word address is 9 bits. Bits [2:0] select one of 8 banks and bits [8:3] select the word within that bank. Address arithmetic wraps modulo 512.
- R3: In strided mode (`req_indexed`=0), element i has address `req_base + i*req_stride`, modulo 512.
- R4: In indexed mode (`req_indexed`=1), element i has address `req_base + req_index[9*i+8:9*i]`, modulo 512. This mode serves gather for loads and scatter for stores.
- R5: A store writes lane i's word, `req_wdata[32*i+31:32*i]`, to element i's address. Elements that share a bank are written in ascending element order, so when two elements have the same address the higher-numbered element's data remains.
- R6: Let K be the largest number of active elements that map to any one bank, with a minimum of 1. `rsp_valid` is first seen high after the (K+2)-th rising edge, counting the edge that accepts the request as the first.
- R7: `rsp_valid` is high for exactly one cycle. For a load, lane i of `rsp_data` holds the word read for element i. Lanes at or above `req_len` read as zero. For a store, `rsp_data` is all zero.
- R8: `req_ready` is high only in `S_IDLE`. A `req_valid` pulse while the block is busy is ignored: it causes no memory access and no extra response.
- R9: In any cycle each bank receives at most one access. While elements are pending, the lowest-numbered pending element is always dispatched.
- R10: `req_len` gives the number of active elements, from 1 to 4. Elements at or above `req_len` make no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when `req_ready` is high |
| req_ready | output | 1 | Block idle and able to accept |
| req_store | input | 1 | 1 = store, 0 = load |
| req_indexed | input | 1 | 1 = base plus index, 0 = base plus stride |
| req_len | input | 3 | Active element count, 1 to 4 |
| req_base | input | 9 | Base word address |
| req_stride | input | 9 | Stride in words, used in strided mode |
| req_index | input | 36 | Four 9-bit per-element offsets, element 0 in the low bits |
| req_wdata | input | 128 | Four 32-bit store words, lane 0 in the low bits |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_data | output | 128 | Loaded words in element order, lane 0 in the low bits |

## Verification
Assertions check the dispatch rules on every cycle. They check that no bank is granted twice, that grants only go to pending elements, that the oldest pending element always makes progress, and that nothing new becomes pending while the block is busy. They also check that the completion strobe lasts one cycle, that it never overlaps readiness, and that nothing is pending when it fires. Other behaviour shows up only in the bench's scenarios, which compare against a memory model held in the bench. These include whether the address arithmetic and bank split put data in the right words, whether the last writer wins on a repeated address, the exact completion latency for each conflict pattern, and whether a request sent while busy is dropped.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_DRAIN = 2'd2,
        S_DONE  = 2'd3
    } mover_state_e;
endpackage

// File: rtl/vbm_bank.sv
module vbm_bank #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 6
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DATA_W-1:0] store_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store_mem[addr] <= wdata;
            end else begin
                rdata <= store_mem[addr];
            end
        end
    end
endmodule

// File: rtl/vbm_addr_gen.sv
module vbm_addr_gen #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 9
) (
    input  logic                          indexed,
    input  logic [ADDR_W-1:0]             base,
    input  logic [ADDR_W-1:0]             stride,
    input  logic [LANES-1:0][ADDR_W-1:0]  index,
    output logic [LANES-1:0][ADDR_W-1:0]  addr
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [ADDR_W-1:0] POS = ADDR_W'(i);
        logic [ADDR_W-1:0] step_off;
        assign step_off = POS * stride;
        assign addr[i]  = indexed ? (base + index[i]) : (base + step_off);
    end
endmodule

// File: rtl/vbm_bank_arb.sv
module vbm_bank_arb #(
    parameter int LANES  = 4,
    parameter int BANK_W = 3
) (
    input  logic [LANES-1:0]              pending,
    input  logic [LANES-1:0][BANK_W-1:0]  bank,
    output logic [LANES-1:0]              grant
);
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (pending[j] && (bank[j] == bank[i])) begin
                    blocked = 1'b1;
                end
            end
            grant[i] = pending[i] && !blocked;
        end
    end
endmodule

// File: rtl/vec_bank_mover.sv
module vec_bank_mover
    import vbm_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int NBANKS     = 8,
    parameter int BANK_DEPTH = 64,
    parameter int DATA_W     = 32,
    localparam int BANK_W    = $clog2(NBANKS),
    localparam int OFF_W     = $clog2(BANK_DEPTH),
    localparam int ADDR_W    = BANK_W + OFF_W,
    localparam int LEN_W     = $clog2(LANES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_store,
    input  logic                      req_indexed,
    input  logic [LEN_W-1:0]          req_len,
    input  logic [ADDR_W-1:0]         req_base,
    input  logic [ADDR_W-1:0]         req_stride,
    input  logic [LANES*ADDR_W-1:0]   req_index,
    input  logic [LANES*DATA_W-1:0]   req_wdata,
    output logic                      rsp_valid,
    output logic [LANES*DATA_W-1:0]   rsp_data
);
    mover_state_e state_q, state_d;

    logic [LANES-1:0][ADDR_W-1:0]  addr_new;
    logic [LANES-1:0][ADDR_W-1:0]  addr_q;
    logic [LANES-1:0][DATA_W-1:0]  wdata_q;
    logic [LANES-1:0][DATA_W-1:0]  result_q;
    logic [LANES-1:0][BANK_W-1:0]  elem_bank;
    logic [LANES-1:0]              pending_q;
    logic [LANES-1:0]              grant;
    logic [LANES-1:0]              rd_mask_q;
    logic [LANES-1:0]              len_mask;
    logic                          store_q;
    logic                          accept;
    logic                          issuing;

    logic [NBANKS-1:0]             bk_en;
    logic [NBANKS-1:0]             bk_we;
    logic [NBANKS-1:0][OFF_W-1:0]  bk_addr;
    logic [NBANKS-1:0][DATA_W-1:0] bk_wdata;
    logic [NBANKS-1:0][DATA_W-1:0] bk_rdata;

    vbm_addr_gen #(.LANES(LANES), .ADDR_W(ADDR_W)) u_agen (
        .indexed (req_indexed),
        .base    (req_base),
        .stride  (req_stride),
        .index   (req_index),
        .addr    (addr_new)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_elem
        assign elem_bank[i] = addr_q[i][BANK_W-1:0];
        assign len_mask[i]  = (LEN_W'(i) < req_len);
    end

    vbm_bank_arb #(.LANES(LANES), .BANK_W(BANK_W)) u_arb (
        .pending (pending_q),
        .bank    (elem_bank),
        .grant   (grant)
    );

    // Route each granted element to its bank; the arbiter guarantees one per bank.
    always_comb begin
        bk_en    = '0;
        bk_we    = '0;
        bk_addr  = '0;
        bk_wdata = '0;
        for (int b = 0; b < NBANKS; b++) begin
            for (int i = 0; i < LANES; i++) begin
                if (issuing && grant[i] && (elem_bank[i] == BANK_W'(b))) begin
                    bk_en[b]    = 1'b1;
                    bk_we[b]    = store_q;
                    bk_addr[b]  = addr_q[i][ADDR_W-1:BANK_W];
                    bk_wdata[b] = wdata_q[i];
                end
            end
        end
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        vbm_bank #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_bank (
            .clk   (clk),
            .en    (bk_en[b]),
            .we    (bk_we[b]),
            .addr  (bk_addr[b]),
            .wdata (bk_wdata[b]),
            .rdata (bk_rdata[b])
        );
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        issuing   = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = S_ISSUE;
                end
            end
            S_ISSUE: begin
                issuing = 1'b1;
                if ((pending_q & ~grant) == '0) begin
                    state_d = S_DRAIN;
                end
            end
            S_DRAIN: state_d = S_DONE;
            S_DONE: begin
                rsp_valid = 1'b1;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            rd_mask_q <= '0;
            store_q   <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            result_q  <= '0;
        end else begin
            rd_mask_q <= (issuing && !store_q) ? grant : '0;
            if (accept) begin
                pending_q <= len_mask;
                store_q   <= req_store;
                addr_q    <= addr_new;
                wdata_q   <= req_wdata;
                result_q  <= '0;
            end else begin
                if (issuing) begin
                    pending_q <= pending_q & ~grant;
                end
                for (int i = 0; i < LANES; i++) begin
                    if (rd_mask_q[i]) begin
                        result_q[i] <= bk_rdata[elem_bank[i]];
                    end
                end
            end
        end
    end

    assign rsp_data = result_q;
endmodule

// File: rtl/vbm_chk.sv
module vbm_chk #(
    parameter int LANES  = 4,
    parameter int NBANKS = 8,
    parameter int BANK_W = 3
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             req_ready,
    input logic                             rsp_valid,
    input logic [LANES-1:0]                 pending,
    input logic [LANES-1:0]                 grant,
    input logic [LANES-1:0][BANK_W-1:0]     elem_bank
);
    for (genvar b = 0; b < NBANKS; b++) begin : g_bk
        logic [LANES-1:0] hit;
        always_comb begin
            for (int i = 0; i < LANES; i++) begin
                hit[i] = grant[i] && (elem_bank[i] == BANK_W'(b));
            end
        end
        assert_one_per_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit));
    end

    assert_grant_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pending) == '0);

    assert_oldest_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> ((grant & pending & (~pending + 1'b1)) != '0));

    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_ready_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    assert_busy_no_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> ((pending & ~$past(pending)) == '0));

    assert_rsp_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (pending == '0));
endmodule

bind vec_bank_mover vbm_chk #(.LANES(LANES), .NBANKS(NBANKS), .BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .pending   (pending_q),
    .grant     (grant),
    .elem_bank (elem_bank)
);

// File: tb/test_vec_bank_mover.sv
module test_vec_bank_mover;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_store = 1'b0, req_indexed = 1'b0;
    logic [2:0] req_len = 3'd1;
    logic [8:0] req_base = '0, req_stride = '0;
    logic [3:0][8:0]  req_index = '0;
    logic [3:0][31:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [127:0] rsp_data;

    int total = 0, bad = 0, cycles = 0;
    logic [31:0] model [512];

    always #4 clk = ~clk;

    vec_bank_mover i_vec_bank_mover (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_indexed(req_indexed), .req_len(req_len),
        .req_base(req_base), .req_stride(req_stride), .req_index(req_index),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1; total = total + 1;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0][8:0] calc_addr(bit ind, logic [8:0] base, logic [8:0] stride,
                                                  logic [3:0][8:0] idx);
        logic [3:0][8:0] a;
        for (int i = 0; i < 4; i++) a[i] = ind ? 9'(base + idx[i]) : 9'(base + 9'(i) * stride);
        return a;
    endfunction

    function automatic int calc_k(logic [3:0][8:0] a, int len);
        int cnt [8];
        int k = 1;
        for (int b = 0; b < 8; b++) cnt[b] = 0;
        for (int i = 0; i < len; i++) cnt[a[i][2:0]]++;
        for (int b = 0; b < 8; b++) if (cnt[b] > k) k = cnt[b];
        return k;
    endfunction

    // One request with full checking; inject != 0 sends a stray store while busy.
    task automatic run(input bit st, input bit ind, input int len, input logic [8:0] base,
                       input logic [8:0] stride, input logic [3:0][8:0] idx,
                       input logic [3:0][31:0] wd, input bit inject, input string tag);
        logic [3:0][8:0] a;
        logic [127:0] exp;
        int k, n;
        a = calc_addr(ind, base, stride, idx);
        k = calc_k(a, len);
        exp = '0;
        for (int i = 0; i < len; i++) begin
            if (st) model[a[i]] = wd[i];
            else exp[32*i +: 32] = model[a[i]];
        end
        @(negedge clk);
        chk(req_ready === 1'b1, {tag, " R8 ready idle"}, {127'd0, req_ready}, 128'd1);
        req_valid = 1'b1; req_store = st; req_indexed = ind; req_len = 3'(len);
        req_base = base; req_stride = stride; req_index = idx; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (rsp_valid !== 1'b1 && n < 20) begin
            if (n == 0) begin
                chk(req_ready === 1'b0, {tag, " R8 busy not ready"}, {127'd0, req_ready}, 128'd0);
                if (inject) begin
                    req_valid = 1'b1; req_store = 1'b1; req_indexed = 1'b0; req_len = 3'd4;
                    req_base = 9'd300; req_stride = 9'd1; req_wdata = {4{32'hDEAD_BEEF}};
                end
            end
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            n++;
        end
        chk(n == k + 1, {tag, " R6 latency"}, 128'(n), 128'(k + 1));
        chk(rsp_data === exp, {tag, " R7 data"}, rsp_data, exp);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid === 1'b0, {tag, " R7 one-cycle"}, {127'd0, rsp_valid}, 128'd0);
    endtask

    task automatic load1(input logic [8:0] addr, input string tag);
        run(1'b0, 1'b0, 1, addr, 9'd0, '0, '0, 1'b0, tag);
    endtask

    initial begin
        logic [3:0][8:0] idx;
        logic [3:0][31:0] wd;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset state",
            {126'd0, req_ready, rsp_valid}, 128'd2);
        rst_n = 1'b1;

        // Fill memory: stride-1 stores cover all 512 words (R2, R3, R10)
        for (int blk = 0; blk < 128; blk++) begin
            for (int i = 0; i < 4; i++) wd[i] = $urandom;
            run(1'b1, 1'b0, 4, 9'(blk * 4), 9'd1, '0, wd, 1'b0, "R5 fill store");
        end

        // R3: stride equal to the bank count, every element in one bank
        run(1'b0, 1'b0, 4, 9'd5, 9'd8, '0, '0, 1'b0, "R3 stride8 same bank");
        // R3: unit stride load, no conflict
        run(1'b0, 1'b0, 4, 9'd40, 9'd1, '0, '0, 1'b0, "R3 unit stride");
        // R5: stride 0 store, highest element must win
        wd = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
        run(1'b1, 1'b0, 4, 9'd17, 9'd0, '0, wd, 1'b0, "R5 same address store");
        load1(9'd17, "R5 last writer wins");
        // R4: gather with two pairwise conflicts
        idx = {9'd9, 9'd1, 9'd8, 9'd0};
        run(1'b0, 1'b1, 4, 9'd100, 9'd0, idx, '0, 1'b0, "R4 gather");
        // R4: scatter then read back each element
        idx = {9'd3, 9'd200, 9'd64, 9'd7};
        wd = {32'hAAAA_0003, 32'hAAAA_0002, 32'hAAAA_0001, 32'hAAAA_0000};
        run(1'b1, 1'b1, 4, 9'd250, 9'd0, idx, wd, 1'b0, "R4 scatter");
        run(1'b0, 1'b1, 4, 9'd250, 9'd0, idx, '0, 1'b0, "R4 gather after scatter");
        // R2: wrap past the top of the address space
        run(1'b0, 1'b0, 4, 9'd510, 9'd1, '0, '0, 1'b0, "R2 wrap");
        // R10 / R7: short vector, upper lanes zero and untouched
        wd = {4{32'hFFFF_FFFF}};
        run(1'b1, 1'b0, 2, 9'd60, 9'd1, '0, wd, 1'b0, "R10 short store");
        run(1'b0, 1'b0, 4, 9'd60, 9'd1, '0, '0, 1'b0, "R10 upper lanes untouched");
        run(1'b0, 1'b0, 2, 9'd60, 9'd1, '0, '0, 1'b0, "R7 short load zero lanes");
        // R8: stray request while busy must not write address 300..303
        run(1'b0, 1'b0, 4, 9'd8, 9'd16, '0, '0, 1'b1, "R8 busy inject");
        run(1'b0, 1'b0, 4, 9'd300, 9'd1, '0, '0, 1'b0, "R8 stray store ignored");

        // Constrained random mix (R2..R10)
        for (int t = 0; t < 400; t++) begin
            for (int i = 0; i < 4; i++) begin
                idx[i] = 9'($urandom);
                wd[i]  = $urandom;
            end
            run(1'($urandom), 1'($urandom), 1 + int'($urandom % 4), 9'($urandom),
                9'($urandom % 20), idx, wd, 1'b0, "R9 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule